// File: doc/BRIEF.md
# Input Pin Change-of-State Monitor

This block watches a small group of general-purpose input pins and presents them to a CPU as one register. The low half of the register shows each pin's present level. The high half holds a sticky change flag for each pin. A flag sets when its pin settles at a new level, and it stays set until the CPU reads the register.

Each pin enters through a two-flop synchronizer. A free-running divider then produces sample ticks. The block accepts a new level only after two consecutive ticks see the same value that differs from the last accepted level, so short pulses are rejected.

A per-pin enable vector decides which accepted changes also raise a single input-change status bit, which feeds the chip's interrupt logic. A disabled pin still records its change flag but leaves the status bit alone. A register read strobe clears every change flag and the status bit in one cycle. A change accepted in the same cycle as that read survives it.

Top module: `pin_change_monitor`

## Requirements
- R1: `reg_o[3:0]` shows the pin levels through a two-flop synchronizer. A pin change driven before a rising edge appears after the second rising edge and not after the first. Bit i corresponds to pin i.
- R2: `reg_o[4+i]` sets when pin i settles at a new level that has been seen on two consecutive sample ticks.
- R3: A set change flag stays set, with no read, however long the pins then stay quiet.
- R4: A cycle with `rd_i` high clears all four change flags.
- R5: A cycle with `rd_i` high clears `chg_irq_o`.
- R6: `chg_irq_o` sets when a pin whose bit in `irq_en_i` is 1 has a change accepted. A change on a pin whose enable bit is 0 sets that pin's flag but not `chg_irq_o`. `chg_irq_o` is never high while all flags are clear.
- R7: A change accepted in the same cycle as a read is kept. Its flag, and the status bit if that pin is enabled, are high in the following cycle.
- R8: A pulse shorter than one sample period sets no change flag.
- R9: While `rst_ni` is low, `reg_o` is 0 and `chg_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 4 | Asynchronous input pins |
| irq_en_i | input | 4 | Per-pin enable for the status bit |
| rd_i | input | 1 | Register read strobe, one cycle per read |
| reg_o | output | 8 | Change flags [7:4], live levels [3:0] |
| chg_irq_o | output | 1 | Input-change status bit |

## Verification
The assertions check on every cycle the relations between accepted change events, the read strobe, the flags and the status bit:
- flags stay sticky;
- a read clears the flags and the status bit;
- a coinciding event wins over a clear;
- the status bit rises only on an enabled event and never without a flag.

Only the bench scenarios can show the parts that depend on how pins behave over time: the synchronizer latency, acceptance after two agreeing ticks, rejection of short pulses, and the mapping of pin patterns and enables to flags.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned DEF_PINS    = 4;
  localparam int unsigned DEF_DIV     = 8;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = pcd_pkg::SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcd_tick.sv
module pcd_tick #(
  parameter int unsigned DIV = pcd_pkg::DEF_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (cnt_q == LAST)   cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pcd_filter.sv
module pcd_filter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] evt_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic samp_q, acc_q, take;
    // accept when this tick agrees with the previous tick and differs from accepted level
    assign take     = tick_i && (lvl_i[b] == samp_q) && (lvl_i[b] != acc_q);
    assign evt_o[b] = take;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        samp_q <= 1'b0;
        acc_q  <= 1'b0;
      end else begin
        if (tick_i) samp_q <= lvl_i[b];
        if (take)   acc_q  <= lvl_i[b];
      end
    end
  end
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor #(
  parameter int unsigned N_PINS     = pcd_pkg::DEF_PINS,
  parameter int unsigned SAMPLE_DIV = pcd_pkg::DEF_DIV
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PINS-1:0]   pins_i,
  input  logic [N_PINS-1:0]   irq_en_i,
  input  logic                rd_i,
  output logic [2*N_PINS-1:0] reg_o,
  output logic                chg_irq_o
);
  logic [N_PINS-1:0] lvl_sync;
  logic [N_PINS-1:0] chg_evt;
  logic              tick;
  logic [N_PINS-1:0] flag_q;
  logic              stat_q;

  pcd_sync #(.WIDTH(N_PINS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (lvl_sync)
  );

  pcd_tick #(.DIV(SAMPLE_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  pcd_filter #(.WIDTH(N_PINS)) i_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .lvl_i (lvl_sync),
    .evt_o (chg_evt)
  );

  // set wins over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      stat_q <= 1'b0;
    end else begin
      flag_q <= (rd_i ? '0 : flag_q) | chg_evt;
      stat_q <= (rd_i ? 1'b0 : stat_q) | (|(chg_evt & irq_en_i));
    end
  end

  assign reg_o     = {flag_q, lvl_sync};
  assign chg_irq_o = stat_q;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int unsigned N_PINS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_i,
  input logic [N_PINS-1:0]   irq_en_i,
  input logic [2*N_PINS-1:0] reg_o,
  input logic                chg_irq_o,
  input logic [N_PINS-1:0]   evt_i
);
  logic [N_PINS-1:0] flags;
  assign flags = reg_o[2*N_PINS-1:N_PINS];

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((flags & $past(flags)) == $past(flags)));

  p_rd_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && evt_i == '0) |=> (flags == '0));

  p_rd_clr_stat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (evt_i & irq_en_i) == '0) |=> !chg_irq_o);

  p_stat_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg_irq_o && (evt_i & irq_en_i) == '0) |=> !chg_irq_o);

  p_stat_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_irq_o |-> (flags != '0));

  p_evt_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  p_evt_stat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & irq_en_i) != '0) |=> chg_irq_o);
endmodule

bind pin_change_monitor pcd_checker #(.N_PINS(N_PINS)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .irq_en_i (irq_en_i),
  .reg_o    (reg_o),
  .chg_irq_o(chg_irq_o),
  .evt_i    (chg_evt)
);

// File: tb/test_pin_change_monitor.sv
module test_pin_change_monitor;
  localparam int unsigned DIV = 4;
  localparam int unsigned SETTLE = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pins_i = '0;
  logic [3:0] irq_en_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] reg_o;
  logic       chg_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pin_change_monitor #(.N_PINS(4), .SAMPLE_DIV(DIV)) i_pin_change_monitor (
    .clk_i, .rst_ni, .pins_i, .irq_en_i, .rd_i, .reg_o, .chg_irq_o
  );

  // {pins, enables, expected flags, expected status}
  localparam logic [12:0] VEC [6] = '{
    {4'b0001, 4'b1111, 4'b0001, 1'b1},
    {4'b0011, 4'b0000, 4'b0010, 1'b0},
    {4'b1100, 4'b0100, 4'b1111, 1'b1},
    {4'b1000, 4'b1000, 4'b0100, 1'b0},
    {4'b1000, 4'b1111, 4'b0000, 1'b0},
    {4'b0111, 4'b0001, 4'b1111, 1'b1}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    cyc(1);
    rd_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check("R9 reset", {chg_irq_o, reg_o}, 9'h000);
    rst_ni = 1'b1;
    cyc(SETTLE);
    check("R9 idle after reset", {chg_irq_o, reg_o}, 9'h000);

    // table walk: R2 R4 R5 R6 R3
    for (int v = 0; v < 6; v++) begin
      pins_i   = VEC[v][12:9];
      irq_en_i = VEC[v][8:5];
      cyc(SETTLE);
      check("R2/R6 flags+status", {chg_irq_o, reg_o}, {VEC[v][0], VEC[v][4:1], VEC[v][12:9]});
      cyc(SETTLE);
      check("R3 sticky", {chg_irq_o, reg_o}, {VEC[v][0], VEC[v][4:1], VEC[v][12:9]});
      do_read();
      check("R4/R5 read clears", {chg_irq_o, reg_o}, {1'b0, 4'b0000, VEC[v][12:9]});
    end

    // R1: two-flop latency
    pins_i = 4'b1010;
    cyc(1);
    check("R1 not after first edge", {1'b0, reg_o[3:0], 4'b0}, {1'b0, 4'b0111, 4'b0});
    cyc(1);
    check("R1 after second edge", {1'b0, reg_o[3:0], 4'b0}, {1'b0, 4'b1010, 4'b0});
    cyc(SETTLE);
    do_read();
    check("R4 cleared before glitch test", {chg_irq_o, reg_o}, {1'b0, 4'b0000, 4'b1010});

    // R8: short pulse on pin 0
    irq_en_i = 4'b1111;
    pins_i = 4'b1011;
    cyc(DIV - 1);
    pins_i = 4'b1010;
    cyc(SETTLE);
    check("R8 short pulse ignored", {chg_irq_o, reg_o}, {1'b0, 4'b0000, 4'b1010});

    // R7: change while read is held every cycle
    begin
      bit seen_f = 0;
      bit seen_s = 0;
      rd_i = 1'b1;
      pins_i = 4'b0010;
      for (int i = 0; i < SETTLE; i++) begin
        cyc(1);
        if (reg_o[7:4] == 4'b1000) seen_f = 1;
        if (chg_irq_o) seen_s = 1;
      end
      rd_i = 1'b0;
      cyc(1);
      check("R7 flag kept over read", {8'b0, seen_f}, 9'b1);
      check("R7 status kept over read", {8'b0, seen_s}, 9'b1);
      check("R4 cleared after held read", {chg_irq_o, reg_o}, {1'b0, 4'b0000, 4'b0010});
    end

    // R9: reset with flags pending
    pins_i = 4'b0101;
    cyc(SETTLE);
    check("R2/R6 before reset", {chg_irq_o, reg_o}, {1'b1, 4'b0111, 4'b0101});
    rst_ni = 1'b0;
    cyc(2);
    check("R9 reset mid-run", {chg_irq_o, reg_o}, 9'h000);
    pins_i = 4'b0000;
    rst_ni = 1'b1;
    cyc(SETTLE);
    check("R9 quiet after release", {chg_irq_o, reg_o}, 9'h000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule